// File: doc/BRIEF.md
# PLL Lock Qualification Controller

This block sits beside a phase-locked loop and turns the loop's raw, possibly glitchy lock indication into a qualified lock. The block runs on the reference clock. A global enable starts and stops the loop. An asynchronous reset puts the whole controller into a known state.

After reset is released, or when the enable rises, the block starts the loop and restarts its qualification counter in the same cycle. The counter then counts reference cycles during which the synchronized lock stays high. The qualified lock asserts only when a programmable threshold is reached. While the block is disabled, every clock-output enable is held low and both lock outputs are low.

Any drop of lock while the block is enabled sets a sticky flag. The flag tells the system that the loop must be reset to restore phase alignment between its output clocks. Only the asynchronous reset clears this flag. A wrapping counter of clean starts lets the surrounding logic confirm that each restart happened.

Top module: `pll_lock_qual`

## Requirements
- R1: Raising `pll_rst_i` clears all state and outputs at once, without waiting for a clock edge. After `pll_rst_i` falls, internal reset ends on the second rising reference edge. With `glob_en_i` high, `pll_en_o` rises on the third edge.
- R2: `raw_lock_i` passes through a two-stage synchronizer. `lock_o` is the synchronized lock ANDed with the run state, so it rises on the second edge after `raw_lock_i` rises.
- R3: Let THRESH be the threshold. `gated_lock_o` rises THRESH+1 edges after the first edge at which the synchronized lock is high while the block runs, provided lock holds throughout. When the synchronized lock falls, `gated_lock_o` falls with it.
- R4: If the synchronized lock falls before the threshold is reached, the counter returns to zero. Qualification then needs a fresh unbroken run of THRESH+1 edges.
- R5: While the registered enable is low, `pll_en_o`, `lock_o`, `gated_lock_o` and every bit of `clk_out_en_o` are 0. All of them go low on the first edge after `glob_en_i` falls.
- R6: When the enable rises again with lock already present, qualification restarts from zero. `gated_lock_o` rises THRESH+1 edges after `pll_en_o` rises.
- R7: A fall of the synchronized lock while the block runs sets `reset_req_o` one edge after the synchronized lock falls. A loss caused by disabling the block does not set it.
- R8: `reset_req_o` stays set through disable and re-enable cycles. Only `pll_rst_i` clears it.
- R9: `restart_cnt_o` increments, wrapping, on the same edge at which `pll_en_o` rises. Because the filter counter is held at zero until that edge, the counter and the loop start together.
- R10: Bit i of `clk_out_en_o` follows `gated_lock_o` when bit i of parameter GATE_MASK is 1. Otherwise it follows `pll_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| pll_rst_i | input | 1 | Asynchronous reset, active high |
| glob_en_i | input | 1 | Global enable for the loop, synchronous to clk_ref |
| raw_lock_i | input | 1 | Raw lock indication from the loop, asynchronous |
| pll_en_o | output | 1 | Run/enable to the loop |
| lock_o | output | 1 | Synchronized lock, gated by run state |
| gated_lock_o | output | 1 | Qualified lock |
| reset_req_o | output | 1 | Sticky flag: lock was lost, loop reset required |
| clk_out_en_o | output | NOUT | Per-output clock enables |
| restart_cnt_o | output | RC_W | Count of clean starts, wrapping |

## Verification
The assertions assume that `glob_en_i` is synchronous to `clk_ref`. They also assume that `pll_rst_i` is high from time zero until the first edges have passed, so their reset guard covers the power-up state. The bench changes every input on the falling clock edge. It keeps reset asserted for several cycles at start-up, and it pulses reset only after the loop has run. Lock glitches are modelled as whole-cycle pulses of the raw lock, which the synchronizer samples cleanly.

// File: rtl/pll_lq_pkg.sv
package pll_lq_pkg;

   // how a clock-output enable is qualified
   typedef enum logic {
      GATE_ON_RUN  = 1'b0,
      GATE_ON_LOCK = 1'b1
   } gate_mode_e;

   localparam int unsigned DEF_CNT_W = 16;
   localparam int unsigned MIN_SYNC  = 2;

endpackage

// File: rtl/pll_lq_sync.sv
module pll_lq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   import pll_lq_pkg::*;

   initial begin
      assert (STAGES >= MIN_SYNC) else $error("pll_lq_sync: STAGES too small");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

   // R1 R2: the output can only rise once the stage before it was already high
   // R2
   sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_o) |-> $past(chain_q[STAGES-2]));

endmodule

// File: rtl/pll_lq_filter.sv
module pll_lq_filter #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned THRESH = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic lock_i,
   output logic qual_o
);
   localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);

   initial begin
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("pll_lq_filter: bad CNT_W");
      assert (THRESH < (64'd1 << CNT_W)) else $error("pll_lq_filter: THRESH too wide");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             qual_q;
   logic             hit;

   assign hit = (cnt_q == THR_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         qual_q <= 1'b0;
      end else if (!run_i || !lock_i) begin
         cnt_q  <= '0;
         qual_q <= 1'b0;
      end else if (hit) begin
         qual_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign qual_o = qual_q & lock_i & run_i;

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= THR_V);

   // R3
   qual_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual_q) |-> $past(run_i && lock_i && cnt_q == THR_V));

   // R4
   drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !lock_i) |=> (cnt_q == '0 && !qual_q));

   // R5 R6
   idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0 && !qual_q));

endmodule

// File: rtl/pll_lock_qual.sv
module pll_lock_qual #(
   parameter int unsigned     CNT_W     = pll_lq_pkg::DEF_CNT_W,
   parameter int unsigned     THRESH    = 1000,
   parameter int unsigned     SYNC_N    = 2,
   parameter int unsigned     NOUT      = 4,
   parameter logic [NOUT-1:0] GATE_MASK = '1,
   parameter int unsigned     RC_W      = 8
) (
   input  logic            clk_ref,
   input  logic            pll_rst_i,
   input  logic            glob_en_i,
   input  logic            raw_lock_i,
   output logic            pll_en_o,
   output logic            lock_o,
   output logic            gated_lock_o,
   output logic            reset_req_o,
   output logic [NOUT-1:0] clk_out_en_o,
   output logic [RC_W-1:0] restart_cnt_o
);
   import pll_lq_pkg::*;

   initial begin
      assert (NOUT >= 1) else $error("pll_lock_qual: NOUT must be positive");
      assert (RC_W >= 1) else $error("pll_lock_qual: RC_W must be positive");
   end

   logic arst_n;
   logic srst_n;
   logic lk_s;
   logic lk_prev_q;
   logic run_q;
   logic req_q;
   logic qual;
   logic [RC_W-1:0] rcnt_q;

   assign arst_n = ~pll_rst_i;

   // reset: asserted at once, released through the synchronizer
   pll_lq_sync #(.STAGES(2)) u_rst_sync (
      .clk   (clk_ref),
      .rst_n (arst_n),
      .d_i   (1'b1),
      .q_o   (srst_n)
   );

   pll_lq_sync #(.STAGES(SYNC_N)) u_lock_sync (
      .clk   (clk_ref),
      .rst_n (srst_n),
      .d_i   (raw_lock_i),
      .q_o   (lk_s)
   );

   // run state and restart counter move on the same edge
   always_ff @(posedge clk_ref or negedge srst_n) begin
      if (!srst_n) begin
         run_q  <= 1'b0;
         rcnt_q <= '0;
      end else begin
         run_q <= glob_en_i;
         if (glob_en_i && !run_q) rcnt_q <= rcnt_q + 1'b1;
      end
   end

   pll_lq_filter #(.CNT_W(CNT_W), .THRESH(THRESH)) u_filter (
      .clk    (clk_ref),
      .rst_n  (srst_n),
      .run_i  (run_q),
      .lock_i (lk_s),
      .qual_o (qual)
   );

   // sticky loss flag
   always_ff @(posedge clk_ref or negedge srst_n) begin
      if (!srst_n) begin
         lk_prev_q <= 1'b0;
         req_q     <= 1'b0;
      end else begin
         lk_prev_q <= lk_s;
         if (run_q && lk_prev_q && !lk_s) req_q <= 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < NOUT; i++) begin : g_out
         if (gate_mode_e'(GATE_MASK[i]) == GATE_ON_LOCK) begin : g_lock
            assign clk_out_en_o[i] = qual;
         end else begin : g_run
            assign clk_out_en_o[i] = run_q;
         end
      end
   endgenerate

   assign pll_en_o      = run_q;
   assign lock_o        = lk_s & run_q;
   assign gated_lock_o  = qual;
   assign reset_req_o   = req_q;
   assign restart_cnt_o = rcnt_q;

   // R8
   req_sticky_chk: assert property (@(posedge clk_ref) disable iff (!srst_n)
      req_q |=> req_q);

   // R9
   restart_step_chk: assert property (@(posedge clk_ref) disable iff (!srst_n)
      $rose(run_q) |-> rcnt_q == $past(rcnt_q) + 1'b1);

   // R5
   idle_outputs_chk: assert property (@(posedge clk_ref) disable iff (!srst_n)
      $fell(glob_en_i) |=> (clk_out_en_o == '0 && !gated_lock_o && !lock_o));

   // R7
   loss_flag_chk: assert property (@(posedge clk_ref) disable iff (!srst_n)
      (run_q && $fell(lk_s)) |=> req_q);

endmodule

// File: tb/tb_pll_lock_qual.sv
module tb_pll_lock_qual;
   localparam int PERIOD = 10;
   localparam int THR    = 5;
   localparam int NOUT   = 4;
   localparam int RC_W   = 8;

   logic clk_ref = 1'b0;
   logic pll_rst_i = 1'b1;
   logic glob_en_i = 1'b1;
   logic raw_lock_i = 1'b0;
   logic pll_en_o, lock_o, gated_lock_o, reset_req_o;
   logic [NOUT-1:0] clk_out_en_o;
   logic [RC_W-1:0] restart_cnt_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(PERIOD/2) clk_ref = ~clk_ref;

   pll_lock_qual #(
      .CNT_W(16), .THRESH(THR), .SYNC_N(2), .NOUT(NOUT),
      .GATE_MASK(4'b0011), .RC_W(RC_W)
   ) dut (
      .clk_ref(clk_ref), .pll_rst_i(pll_rst_i), .glob_en_i(glob_en_i),
      .raw_lock_i(raw_lock_i), .pll_en_o(pll_en_o), .lock_o(lock_o),
      .gated_lock_o(gated_lock_o), .reset_req_o(reset_req_o),
      .clk_out_en_o(clk_out_en_o), .restart_cnt_o(restart_cnt_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk_ref);
   endtask

   task automatic t_reset_start();
      step(2);
      chk("R1 held", {pll_en_o, lock_o, gated_lock_o, reset_req_o}, 4'b0000);
      chk("R1 held cnt", restart_cnt_o, 0);
      pll_rst_i = 1'b0;
      step(2);
      chk("R1 not yet", pll_en_o, 1'b0);
      step(1);
      chk("R1 run", pll_en_o, 1'b1);
      chk("R9 restart", restart_cnt_o, 1);
      chk("R10 run outs", clk_out_en_o, 4'b1100);
   endtask

   task automatic t_qualify();
      raw_lock_i = 1'b1;
      step(1);
      chk("R2 lock early", lock_o, 1'b0);
      step(1);
      chk("R2 lock", lock_o, 1'b1);
      step(5);
      chk("R3 not yet", gated_lock_o, 1'b0);
      step(1);
      chk("R3 gated", gated_lock_o, 1'b1);
      chk("R10 all outs", clk_out_en_o, 4'b1111);
   endtask

   task automatic t_loss_glitch();
      raw_lock_i = 1'b0;
      step(2);
      chk("R3 gated drops", gated_lock_o, 1'b0);
      chk("R7 not yet", reset_req_o, 1'b0);
      step(1);
      chk("R7 flag", reset_req_o, 1'b1);
      raw_lock_i = 1'b1;
      step(3);
      raw_lock_i = 1'b0;
      for (int i = 0; i < 8; i++) begin
         step(1);
         chk("R4 glitch", gated_lock_o, 1'b0);
      end
      raw_lock_i = 1'b1;
      step(7);
      chk("R4 from zero", gated_lock_o, 1'b0);
      step(1);
      chk("R4 requal", gated_lock_o, 1'b1);
   endtask

   task automatic t_disable();
      glob_en_i = 1'b0;
      step(1);
      chk("R5 outputs", {pll_en_o, lock_o, gated_lock_o, clk_out_en_o}, 7'b0);
      chk("R8 kept", reset_req_o, 1'b1);
      step(4);
      chk("R5 still", clk_out_en_o, 4'b0000);
      glob_en_i = 1'b1;
      step(1);
      chk("R9 en", pll_en_o, 1'b1);
      chk("R9 cnt", restart_cnt_o, 2);
      step(5);
      chk("R6 not yet", gated_lock_o, 1'b0);
      step(1);
      chk("R6 requal", gated_lock_o, 1'b1);
      chk("R8 kept2", reset_req_o, 1'b1);
   endtask

   task automatic t_disable_no_flag();
      // clear flag by reset, then disable with lock present
      pll_rst_i = 1'b1;
      #1;
      chk("R1 async", {pll_en_o, reset_req_o, gated_lock_o}, 3'b000);
      chk("R8 cleared", restart_cnt_o, 0);
      step(1);
      pll_rst_i = 1'b0;
      step(3);
      chk("R9 after rst", restart_cnt_o, 1);
      step(6);
      chk("R3 after rst early", gated_lock_o, 1'b0);
      step(1);
      chk("R3 after rst", gated_lock_o, 1'b1);
      glob_en_i = 1'b0;
      step(4);
      glob_en_i = 1'b1;
      step(3);
      chk("R7 disable no flag", reset_req_o, 1'b0);
   endtask

   initial begin
      t_reset_start();
      t_qualify();
      t_loss_glitch();
      t_disable();
      t_disable_no_flag();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 5000);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule